// File: doc/BRIEF.md
# 100 Mb/s Stream Delimiter Detector

This block sits after the descrambler in a 100 Mb/s receive path and takes one aligned 5-bit code group per clock. It watches the stream through a two-group (10-bit) window. The window finds the start delimiter and rejects false carrier, then decodes data symbols into nibbles. It also finds the end delimiter and flags packets that stop without one. The output is a nibble-wide receive interface with carrier sense, data valid, receive error and data. Two sticky status bits record a bad start delimiter and a bad end delimiter.

Each output nibble belongs to the code group that came in two clocks earlier. The decision for a group needs the group that follows it, so the window holds both. The sticky bits stay set until a one-cycle clear strobe arrives, and then they drop.

Top module: `stream_delim_det`

## Requirements
- R1: After reset, crs_o, rx_dv_o, rx_er_o, rxd_o, bad_ssd_o and bad_esd_o are all 0.
- R2: Code groups are MSB first, with J=11000, K=10001, I=11111, T=01101, R=00111, and data 0..F = 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. When idle, the pair J then K produces two nibbles with crs_o=1, rx_dv_o=0 and rxd_o=0101. Each later data group produces crs_o=1, rx_dv_o=1 and its decoded nibble. The output for a group appears two clocks after it is driven.
- R3: When idle, a 10-bit window that is neither I,I nor J,K is ignored if all its zero bits form a single contiguous run (or it has no zeros). Outputs stay 0 and no status bit is set.
- R4: When idle, a window that is neither I,I nor J,K and holds zeros in two or more separate runs is a false carrier. Its first group emits crs_o=1, rx_er_o=1, rx_dv_o=0 and rxd_o=1110, and bad_ssd_o is set.
- R5: After a false carrier, every window, including J,K, is ignored with all outputs 0 until an I,I pair has been seen.
- R6: During reception, the pair T,R emits two nibbles with crs_o=1, rx_dv_o=0, rx_er_o=0 and rxd_o=0000, which stand in for idle. crs_o falls on the next group.
- R7: During reception, an I,I pair with no T,R before it emits for the first I: crs_o=1, rx_dv_o=1, rx_er_o=1, rxd_o=0000. It sets bad_esd_o, and crs_o falls on the next group.
- R8: During reception, a group that is not a data symbol and does not start a T,R or I,I pair emits rx_dv_o=1, rx_er_o=1, rxd_o=0000. This covers a lone T or a lone I.
- R9: bad_ssd_o and bad_esd_o stay set until stat_clr_i is high at a clock edge, and they are 0 after that edge. A new event in the same cycle as the clear keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one code group per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cg_i | input | 5 | Aligned, descrambled code group, MSB first |
| stat_clr_i | input | 1 | Clear strobe for the sticky status bits |
| crs_o | output | 1 | Carrier sense |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| rxd_o | output | 4 | Receive data nibble |
| bad_ssd_o | output | 1 | Sticky false-carrier status |
| bad_esd_o | output | 1 | Sticky premature-end status |

## Verification
The assertions assume that cg_i already carries group-aligned, descrambled symbols, one per clock. They also assume that stat_clr_i is a plain strobe whose only effect is to drop the status bits. The stimulus holds to this by driving whole code groups on the falling clock edge and pulsing the clear for one cycle. Every packet it sends is followed by idle groups, so an end delimiter is always followed by I. It covers clean packets, noise that must be ignored, a false carrier followed by a J,K inside the lockout, a premature end, and bad data-phase symbols. Each expected nibble is stated per group from the requirements.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_J = 5'b11000;
  localparam cg_t CG_K = 5'b10001;
  localparam cg_t CG_I = 5'b11111;
  localparam cg_t CG_T = 5'b01101;
  localparam cg_t CG_R = 5'b00111;

  typedef enum logic [2:0] {ST_IDLE, ST_SSD_K, ST_DATA, ST_END_R, ST_LOCK} st_e;

  typedef struct packed {
    logic             crs;
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] nib;
  } rx_nib_t;

  // returns {valid, nibble}
  function automatic logic [NIB_W:0] dec_sym(cg_t c);
    unique case (c)
      5'b11110: dec_sym = 5'h10;
      5'b01001: dec_sym = 5'h11;
      5'b10100: dec_sym = 5'h12;
      5'b10101: dec_sym = 5'h13;
      5'b01010: dec_sym = 5'h14;
      5'b01011: dec_sym = 5'h15;
      5'b01110: dec_sym = 5'h16;
      5'b01111: dec_sym = 5'h17;
      5'b10010: dec_sym = 5'h18;
      5'b10011: dec_sym = 5'h19;
      5'b10110: dec_sym = 5'h1a;
      5'b10111: dec_sym = 5'h1b;
      5'b11010: dec_sym = 5'h1c;
      5'b11011: dec_sym = 5'h1d;
      5'b11100: dec_sym = 5'h1e;
      5'b11101: dec_sym = 5'h1f;
      default:  dec_sym = 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/sdd_window.sv
module sdd_window
  import sdd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cg_t  cg_i,
  output cg_t  cur_o,
  output logic is_jk_o,
  output logic is_ii_o,
  output logic is_tr_o,
  output logic noise_o
);
  localparam int WIN_W = 2 * CG_W;
  localparam int CNT_W = $clog2(WIN_W + 1);

  cg_t              cur_q;
  logic [WIN_W-1:0] zeros;
  logic [WIN_W:0]   zext;
  logic [CNT_W-1:0] runs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= CG_I;
    else         cur_q <= cg_i;
  end

  assign zeros = ~{cur_q, cg_i};
  assign zext  = {1'b0, zeros};

  // count separate runs of zeros in the window
  always_comb begin
    runs = '0;
    for (int k = 0; k < WIN_W; k++)
      if (zext[k] && !zext[k+1]) runs = runs + CNT_W'(1);
  end

  assign cur_o   = cur_q;
  assign is_jk_o = (cur_q == CG_J) && (cg_i == CG_K);
  assign is_ii_o = (cur_q == CG_I) && (cg_i == CG_I);
  assign is_tr_o = (cur_q == CG_T) && (cg_i == CG_R);
  assign noise_o = (runs >= CNT_W'(2));
endmodule

// File: rtl/sdd_sticky.sv
module sdd_sticky #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[b] <= 1'b0;
      else if (set_i[b]) q_o[b] <= 1'b1;  // set wins over clear
      else if (clr_i)    q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/stream_delim_det.sv
module stream_delim_det
  import sdd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] cg_i,
  input  logic       stat_clr_i,
  output logic       crs_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic [3:0] rxd_o,
  output logic       bad_ssd_o,
  output logic       bad_esd_o
);
  localparam int NUM_STAT = 2;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_FC  = 4'he;

  cg_t           cur;
  logic          is_jk, is_ii, is_tr, noise;
  st_e           st_q, st_d;
  rx_nib_t       out_q, out_d;
  logic          fc_ev, esd_ev;
  logic [NIB_W:0] dec;
  logic [NUM_STAT-1:0] stat_q;

  sdd_window u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cg_i    (cg_i),
    .cur_o   (cur),
    .is_jk_o (is_jk),
    .is_ii_o (is_ii),
    .is_tr_o (is_tr),
    .noise_o (noise)
  );

  assign dec = dec_sym(cur);

  always_comb begin
    st_d   = st_q;
    out_d  = '0;
    fc_ev  = 1'b0;
    esd_ev = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_jk) begin
          out_d.crs = 1'b1;
          out_d.nib = NIB_PRE;
          st_d      = ST_SSD_K;
        end else if (!is_ii && noise) begin
          out_d.crs = 1'b1;
          out_d.er  = 1'b1;
          out_d.nib = NIB_FC;
          fc_ev     = 1'b1;
          st_d      = ST_LOCK;
        end
      end
      ST_SSD_K: begin
        out_d.crs = 1'b1;
        out_d.nib = NIB_PRE;
        st_d      = ST_DATA;
      end
      ST_DATA: begin
        out_d.crs = 1'b1;
        if (is_tr) begin
          st_d = ST_END_R;          // T,R shown as idle
        end else if (is_ii) begin
          out_d.dv = 1'b1;
          out_d.er = 1'b1;
          esd_ev   = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          out_d.dv = 1'b1;
          if (dec[NIB_W]) out_d.nib = dec[NIB_W-1:0];
          else            out_d.er  = 1'b1;
        end
      end
      ST_END_R: begin
        out_d.crs = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_LOCK: begin
        if (is_ii) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  sdd_sticky #(.N(NUM_STAT)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({esd_ev, fc_ev}),
    .clr_i  (stat_clr_i),
    .q_o    (stat_q)
  );

  assign crs_o     = out_q.crs;
  assign rx_dv_o   = out_q.dv;
  assign rx_er_o   = out_q.er;
  assign rxd_o     = out_q.nib;
  assign bad_ssd_o = stat_q[0];
  assign bad_esd_o = stat_q[1];
endmodule

// File: rtl/sdd_chk.sv
module sdd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stat_clr_i,
  input logic       crs_o,
  input logic       rx_dv_o,
  input logic       rx_er_o,
  input logic [3:0] rxd_o,
  input logic       bad_ssd_o,
  input logic       bad_esd_o
);
  assert_dv_in_crs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |-> crs_o);

  assert_dv_after_crs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> $past(crs_o));

  assert_fc_nibble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_ssd_o) |-> (crs_o && rx_er_o && !rx_dv_o && rxd_o == 4'he));

  assert_esd_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_esd_o) |-> (rx_dv_o && rx_er_o));

  assert_err_nib_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && rx_er_o) |-> (rxd_o == 4'h0));

  assert_ssd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_ssd_o && !stat_clr_i) |=> bad_ssd_o);

  assert_esd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_esd_o && !stat_clr_i) |=> bad_esd_o);
endmodule

bind stream_delim_det sdd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stat_clr_i (stat_clr_i),
  .crs_o      (crs_o),
  .rx_dv_o    (rx_dv_o),
  .rx_er_o    (rx_er_o),
  .rxd_o      (rxd_o),
  .bad_ssd_o  (bad_ssd_o),
  .bad_esd_o  (bad_esd_o)
);

// File: tb/stream_delim_det_test.sv
`timescale 1ns/1ps
module stream_delim_det_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] cg_i = 5'b11111;
  logic       stat_clr_i = 1'b0;
  logic       crs_o, rx_dv_o, rx_er_o, bad_ssd_o, bad_esd_o;
  logic [3:0] rxd_o;

  stream_delim_det uut (.*);

  always #5 clk_i = ~clk_i;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, I = 5'b11111,
                         T = 5'b01101, R = 5'b00111;
  // {crs, dv, er, rxd}
  localparam logic [6:0] QT  = 7'b000_0000;
  localparam logic [6:0] PRE = 7'b100_0101;
  localparam logic [6:0] ENDN = 7'b100_0000;
  localparam logic [6:0] FC  = 7'b101_1110;
  localparam logic [6:0] ERD = 7'b111_0000;

  function automatic logic [4:0] enc(int n);
    case (n)
      0: enc = 5'b11110;  1: enc = 5'b01001;  2: enc = 5'b10100;  3: enc = 5'b10101;
      4: enc = 5'b01010;  5: enc = 5'b01011;  6: enc = 5'b01110;  7: enc = 5'b01111;
      8: enc = 5'b10010;  9: enc = 5'b10011;  10: enc = 5'b10110; 11: enc = 5'b10111;
      12: enc = 5'b11010; 13: enc = 5'b11011; 14: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic logic [6:0] dat(int n);
    dat = {3'b110, 4'(n)};
  endfunction

  typedef struct {
    int         stamp;
    logic [6:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (q.size() > 0 && q[0].stamp == cyc - 2) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, {25'd0, crs_o, rx_dv_o, rx_er_o, rxd_o}, {25'd0, it.exp});
    end
  end

  task automatic send(logic [4:0] cg, logic [6:0] exp, string tag);
    item_t it;
    @(negedge clk_i);
    cg_i = cg;
    it.stamp = cyc;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idles(int n, string tag);
    for (int i = 0; i < n; i++) send(I, QT, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 crs", crs_o, 0);
    check("R1 dv", rx_dv_o, 0);
    check("R1 er", rx_er_o, 0);
    check("R1 rxd", rxd_o, 0);
    check("R1 ssd", bad_ssd_o, 0);
    check("R1 esd", bad_esd_o, 0);
    rst_ni = 1'b1;

    // R2/R6: clean packet
    idles(4, "R2 idle");
    send(J, PRE, "R2 J");
    send(K, PRE, "R2 K");
    send(enc(3), dat(3), "R2 d3");
    send(enc(10), dat(10), "R2 dA");
    send(enc(15), dat(15), "R2 dF");
    send(enc(0), dat(0), "R2 d0");
    send(T, ENDN, "R6 T");
    send(R, ENDN, "R6 R");
    idles(3, "R6 crs drop");
    check("R6 no ssd", bad_ssd_o, 0);
    check("R6 no esd", bad_esd_o, 0);

    // R3: noise ignored
    send(J, QT, "R3 lone J");
    send(I, QT, "R3 idle");
    send(5'b00000, QT, "R3 zeros");
    send(I, QT, "R3 idle");
    send(5'b11011, QT, "R3 one zero");
    idles(3, "R3 idle");
    check("R3 no ssd", bad_ssd_o, 0);

    // R4/R5: false carrier then lockout
    send(I, FC, "R4 fc");
    send(5'b10101, QT, "R5 lock");
    send(J, QT, "R5 J ignored");
    send(K, QT, "R5 K ignored");
    send(I, QT, "R5 lock");
    send(I, QT, "R5 rearm");
    send(J, PRE, "R5 J after rearm");
    send(K, PRE, "R5 K after rearm");
    send(enc(7), dat(7), "R5 d7");
    send(T, ENDN, "R6 T");
    send(R, ENDN, "R6 R");
    idles(4, "R6 idle");
    check("R4 ssd set", bad_ssd_o, 1);
    check("R4 esd clear", bad_esd_o, 0);
    idles(3, "R9 hold");
    check("R9 ssd held", bad_ssd_o, 1);
    stat_clr_i = 1'b1;
    send(I, QT, "R9 clr");
    stat_clr_i = 1'b0;
    send(I, QT, "R9 clr");
    check("R9 ssd cleared", bad_ssd_o, 0);

    // R7: premature end
    send(J, PRE, "R7 J");
    send(K, PRE, "R7 K");
    send(enc(5), dat(5), "R7 d5");
    send(I, ERD, "R7 first I");
    idles(4, "R7 crs drop");
    check("R7 esd set", bad_esd_o, 1);
    check("R7 ssd clear", bad_ssd_o, 0);
    idles(2, "R9 hold");
    check("R9 esd held", bad_esd_o, 1);
    stat_clr_i = 1'b1;
    send(I, QT, "R9 clr");
    stat_clr_i = 1'b0;
    send(I, QT, "R9 clr");
    check("R9 esd cleared", bad_esd_o, 0);

    // R8: invalid data-phase symbols
    send(J, PRE, "R8 J");
    send(K, PRE, "R8 K");
    send(5'b00000, ERD, "R8 bad sym");
    send(T, ERD, "R8 lone T");
    send(enc(9), dat(9), "R8 d9");
    send(I, ERD, "R8 lone I");
    send(enc(2), dat(2), "R8 d2");
    send(T, ENDN, "R6 T");
    send(R, ENDN, "R6 R");
    idles(4, "R8 idle");
    check("R8 no esd", bad_esd_o, 0);

    repeat (3) @(negedge clk_i);
    check("queue drained", q.size(), 0);
    finish_run();
  end
endmodule